// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device holds stuck, for example with SDA pulled low part way through a byte. A one-cycle request starts it. It takes direct control of both bus pads and leaves the normal byte engine out of the path. It first gives nine SCL clocks with SDA released, so a target caught mid-byte can shift out its remaining bits. After that it waits one step and then builds a STOP condition by hand, one pad level at a time. At the end it reads SDA and reports whether the line came free.

The pads are open-drain. A pull-low output at 1 drives the line low, and 0 releases it so the pull-up takes it high. The override output tells the pad mux to take these pull-low outputs instead of the byte engine's. Every step of the sequence lasts `STEP_CYCLES` clock cycles. The default is 500 cycles, which is 5 µs at 100 MHz. There is no data stream: the request, the SDA input and all outputs are plain control and status pins with no handshake.

Top module: `i2c_bus_unjam`

## Requirements
- R1: Out of reset, every output is 0. A `start_i` pulse while idle raises `pad_override_o` and `active_o` from the next cycle, and the sequence begins at step 0.
- R2: Whenever `pad_override_o` is 0, both `scl_pull_low_o` and `sda_pull_low_o` are 0. A pull-low value of 1 drives the line low and 0 releases it.
- R3: Steps 0 to 17 are the clock phase, with `sda_pull_low_o`=0 throughout. SCL is released on the even steps and pulled low on the odd steps, which gives nine high-then-low SCL pulses.
- R4: Step 18 is the gap step: SCL pulled low and SDA released.
- R5: Steps 19 to 22 build the STOP condition, with levels given as (SCL, SDA):
  - step 19: (low, released)
  - step 20: (low, low)
  - step 21: (released, low)
  - step 22: (released, released)
- R6: Each step lasts exactly `STEP_CYCLES` cycles, so `active_o` stays high for 23×`STEP_CYCLES` cycles.
- R7: At the clock edge that ends step 22, `sda_in_i` is sampled. `bus_stuck_o` becomes 1 if the sampled value is 0 and 0 if it is 1, and it keeps that value until the next accepted start, which clears it.
- R8: `done_o` is a one-cycle pulse in the first cycle after the sequence ends. In that same cycle `pad_override_o` and `active_o` are already 0.
- R9: A `start_i` pulse while `active_o` is 1 is ignored: the sequence timing and levels do not change.
- R10: At no clock edge do `scl_pull_low_o` and `sda_pull_low_o` both change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run the recovery sequence; acted on only when idle |
| sda_in_i | input | 1 | Sampled SDA line level |
| pad_override_o | output | 1 | Pads follow the pull-low outputs below, not the byte engine |
| scl_pull_low_o | output | 1 | 1 = drive SCL low, 0 = release |
| sda_pull_low_o | output | 1 | 1 = drive SDA low, 0 = release |
| active_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bus_stuck_o | output | 1 | SDA was still low at the final sample |

## Verification
The bench builds the block with `STEP_CYCLES`=3 and the nine-pulse default. Each run then takes 69 cycles, so several full sequences fit in a short run, and every step boundary can be compared edge by edge against a behavioural model. Within that budget the bench covers three SDA patterns: always released, always held low, and freed after the clock phase. This brings both end results within reach, along with the case where the bus frees partway through. Start requests are also issued in the middle of a run, so the ignore rule is tested at unaligned points within a step.

// File: rtl/unjam_pkg.sv
package unjam_pkg;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } pull_t;

  // Pad pulls for a given step index; pulses = number of SCL clocks.
  function automatic pull_t step_pulls(input int unsigned idx, input int unsigned pulses);
    pull_t p;
    int unsigned tail;
    p = '0;
    if (idx < 2 * pulses) begin
      p.scl_low = idx[0];
    end else begin
      tail = idx - 2 * pulses;
      case (tail)
        0, 1: p.scl_low = 1'b1;
        2: begin
          p.scl_low = 1'b1;
          p.sda_low = 1'b1;
        end
        3: p.sda_low = 1'b1;
        default: p = '0;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/unjam_step_timer.sv
module unjam_step_timer #(
  parameter int unsigned STEP_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_end
);
  localparam int unsigned CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign step_end = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (step_end) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // Step counter never runs past the step length
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // An idle timer restarts from zero
  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/unjam_seq.sv
module unjam_seq #(
  parameter int unsigned TOTAL_STEPS = 23,
  localparam int unsigned IDX_W = $clog2(TOTAL_STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step_end,
  input  logic             sda_in,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output logic             stuck
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_STEPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      done   <= 1'b0;
      stuck  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          idx    <= '0;
          stuck  <= 1'b0;
        end
      end else if (step_end) begin
        if (idx == LAST_IDX) begin
          active <= 1'b0;
          done   <= 1'b1;
          stuck  <= ~sda_in;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // A request mid-run neither restarts nor advances the step index
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !step_end) |=> (active && idx == $past(idx)));

  // Completion marker lasts exactly one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Completion only follows a running sequence
  assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(active) && !active);
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam
  import unjam_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned STEP_CYCLES = CLK_HZ / 200_000,
  parameter int unsigned NUM_PULSES  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sda_in_i,
  output logic pad_override_o,
  output logic scl_pull_low_o,
  output logic sda_pull_low_o,
  output logic active_o,
  output logic done_o,
  output logic bus_stuck_o
);
  localparam int unsigned TOTAL_STEPS = 2 * NUM_PULSES + 5;
  localparam int unsigned IDX_W       = $clog2(TOTAL_STEPS);

  logic             active;
  logic             step_end;
  logic [IDX_W-1:0] idx;
  pull_t            pulls;

  unjam_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (active),
    .step_end (step_end)
  );

  unjam_seq #(.TOTAL_STEPS(TOTAL_STEPS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .step_end (step_end),
    .sda_in   (sda_in_i),
    .active   (active),
    .idx      (idx),
    .done     (done_o),
    .stuck    (bus_stuck_o)
  );

  always_comb begin
    pulls = step_pulls(32'(idx), NUM_PULSES);
    if (!active) pulls = '0;
  end

  assign pad_override_o = active;
  assign active_o       = active;
  assign scl_pull_low_o = pulls.scl_low;
  assign sda_pull_low_o = pulls.sda_low;

  // Without override the pads are never pulled
  assert_release_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_override_o |-> (!scl_pull_low_o && !sda_pull_low_o));

  // Never move both lines on the same edge
  assert_one_line_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(scl_pull_low_o) || $stable(sda_pull_low_o));

  // SDA is only ever pulled while SCL is low or in the STOP steps
  assert_sda_in_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low_o |-> (32'(idx) >= 2 * NUM_PULSES + 1));
endmodule

// File: tb/i2c_bus_unjam_test.sv
module i2c_bus_unjam_test;
  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 3;
  localparam int PULSES     = 9;
  localparam int STEPS      = 2 * PULSES + 5;
  localparam int RUN_LEN    = STEPS * STEP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sda_in_i = 1'b1;
  logic pad_override_o, scl_pull_low_o, sda_pull_low_o, active_o, done_o, bus_stuck_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  bit m_active = 0;
  int m_cyc = 0;
  bit m_done = 0;
  bit m_stuck = 0;
  int sda_mode = 0;   // 0 released, 1 held low, 2 low until clock phase ends
  int done_seen = 0;
  int active_cycles = 0;
  logic prev_scl = 0, prev_sda = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_bus_unjam #(.STEP_CYCLES(STEP), .NUM_PULSES(PULSES)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_in_i(sda_in_i),
    .pad_override_o(pad_override_o), .scl_pull_low_o(scl_pull_low_o),
    .sda_pull_low_o(sda_pull_low_o), .active_o(active_o),
    .done_o(done_o), .bus_stuck_o(bus_stuck_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_cyc = 0; m_done = 0; m_stuck = 0;
    end else begin
      m_done = 0;
      if (!m_active) begin
        if (start_i) begin m_active = 1; m_cyc = 0; m_stuck = 0; end
      end else begin
        m_cyc++;
        if (m_cyc == RUN_LEN) begin
          m_active = 0; m_done = 1; m_stuck = !sda_in_i;
        end
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // expected pulls from the step number, per R3/R4/R5
  function automatic string step_tag(input int s);
    if (s < 2 * PULSES) return "R3 clock phase";
    if (s == 2 * PULSES) return "R4 gap";
    return "R5 stop";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int s;
      bit e_scl, e_sda;
      s = m_cyc / STEP;
      e_scl = 0; e_sda = 0;
      if (m_active) begin
        if (s < 2 * PULSES) e_scl = (s % 2 == 1);
        else if (s == 2 * PULSES || s == 2 * PULSES + 1) e_scl = 1;
        else if (s == 2 * PULSES + 2) begin e_scl = 1; e_sda = 1; end
        else if (s == 2 * PULSES + 3) e_sda = 1;
        check({step_tag(s), " scl R6"}, scl_pull_low_o, e_scl);
        check({step_tag(s), " sda R6"}, sda_pull_low_o, e_sda);
      end else begin
        check("R2 idle scl", scl_pull_low_o, 1'b0);
        check("R2 idle sda", sda_pull_low_o, 1'b0);
      end
      check("R1 override", pad_override_o, m_active);
      check("R9 active", active_o, m_active);
      check("R8 done", done_o, m_done);
      check("R7 stuck", bus_stuck_o, m_stuck);
      checks++;
      if ((scl_pull_low_o !== prev_scl) && (sda_pull_low_o !== prev_sda)) begin
        errors++;
        $display("FAIL R10 both lines moved: actual %0b%0b expected one of them %0b%0b",
                 scl_pull_low_o, sda_pull_low_o, prev_scl, prev_sda);
      end
      prev_scl = scl_pull_low_o; prev_sda = sda_pull_low_o;
      if (done_o) done_seen++;
      if (active_o) active_cycles++;
      // SDA stimulus for the next edge
      case (sda_mode)
        1: sda_in_i = 1'b0;
        2: sda_in_i = !(m_active && m_cyc < 2 * PULSES * STEP);
        default: sda_in_i = 1'b1;
      endcase
    end
  end

  task automatic run_seq(input int mode, input bit spam, input logic exp_stuck);
    sda_mode = mode;
    done_seen = 0;
    active_cycles = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < RUN_LEN + 4; i++) begin
      @(negedge clk);
      start_i = spam && (i % 7 == 2);   // R9: requests while running
    end
    start_i = 1'b0;
    @(negedge clk);
    check("R8 one done pulse", done_seen == 1, 1'b1);
    check("R6 run length", active_cycles == RUN_LEN, 1'b1);
    check("R7 final stuck", bus_stuck_o, exp_stuck);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset override", pad_override_o, 1'b0);
    check("R1 reset done", done_o, 1'b0);
    check("R1 reset stuck", bus_stuck_o, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_seq(0, 1'b0, 1'b0);
    run_seq(1, 1'b1, 1'b1);
    run_seq(2, 1'b1, 1'b0);
    run_seq(1, 1'b0, 1'b1);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule